// File: doc/BRIEF.md
# GPU Request Criticality Scheduler

This block sits beside the GPU side of a memory controller's request queue and picks which queued request goes to DRAM next. The queue's storage is held elsewhere. This block sees only the control events: an enqueue names a free slot and the GPU core that issued the request, and a dequeue names a slot that is being retired. From these events it keeps a table of occupied slots, the owning core of each slot and the arrival order. It also counts how many waiting requests belong to each core.

At the end of each refresh interval, set by a programmable cycle count, each core's share of the queue is turned into a 3-bit criticality level. A core that holds almost the whole queue gets level 0, which is the most urgent. A core that holds almost none of it gets level 7. A core whose level does not exceed a threshold is critical, and all of its waiting requests count as critical requests. The block then measures the fraction of critical requests in the queue. When that fraction is small enough, critical requests are served first. Otherwise the block falls back to the usual row-hit-first, then oldest-first ordering. A row-hit flag for each slot, supplied by the bank-state logic, feeds the ordering. The chosen slot index, its valid flag and the current mode are registered outputs.

Top module: `gpu_crit_sched`

## Requirements
- R1: An enqueue takes effect only when the named slot is free, or is being freed by a dequeue in the same cycle, in which case the slot is taken again as the youngest entry. An enqueue to an occupied slot is ignored. A dequeue of an empty slot is ignored. Each core's pending count is the number of occupied slots that the core owns.
- R2: At a refresh, each core's level is set to 7 - min(7, floor(8*count/total)), where total is the number of occupied slots. If total is 0, the level is 7. Core c's level is reported on `lvl_o[3c+2:3c]`.
- R3: A refresh happens at a clock edge where the interval counter is at least `epoch_len`. The counter then restarts at 0; otherwise it increments. Between refreshes the levels hold their values, so `epoch_len`=0 refreshes the levels at every edge.
- R4: A core is critical when its level is less than or equal to `t_cr`. Every occupied slot owned by a critical core is a critical request.
- R5: `crit_mode_o` is 1 exactly when (number of critical requests)*100 <= `t_ms`*total. An empty queue therefore gives criticality mode.
- R6: In criticality mode the chosen slot is the best one under this order: critical before non-critical, then row hit before miss, then oldest.
- R7: In the other mode the chosen slot is the best one under this order: row hit before miss, then oldest. Criticality plays no part.
- R8: With no occupied slot, `sel_valid_o` is 0 and `sel_idx_o` is 0.
- R9: The outputs are registered. The selection and the mode shown after clock edge e are computed from the slot table, the levels and the inputs as they were just before edge e.
- R10: Synchronous reset empties the table, sets every level to 7, clears the interval counter and drives `sel_valid_o`, `sel_idx_o` and `crit_mode_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue event this cycle |
| enq_idx | input | IDX_W | Slot being filled |
| enq_core | input | CORE_W | GPU core issuing the request |
| deq_valid | input | 1 | Dequeue event this cycle |
| deq_idx | input | IDX_W | Slot being retired |
| row_hit | input | DEPTH | Row-hit flag for each slot |
| t_cr | input | 3 | Criticality level threshold |
| t_ms | input | 7 | Mode-switch percentage threshold |
| epoch_len | input | EPOCH_W | Refresh interval, in cycles minus one |
| sel_valid_o | output | 1 | A slot is selected |
| sel_idx_o | output | IDX_W | Selected slot |
| crit_mode_o | output | 1 | 1 = criticality ordering, 0 = row-hit-first ordering |
| lvl_o | output | 3*NCORE | Criticality level for each core |

## Verification
The hardest case to reach from the ports is a queue where a critical core's requests compete with a non-critical core's row hits. The critical fraction has to sit close to the `t_ms` boundary while the levels are held stale by a long refresh interval. Directed steps first build an 6:2 split between two cores and move `t_ms` across the 600 <= 8*`t_ms` boundary while the row-hit flags change. A long random phase then re-draws `epoch_len`, `t_cr` and `t_ms` every few hundred cycles. In that phase enqueues and dequeues hit the same slot and occupied slots. Each cycle is compared against a reference model held in the bench.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  localparam int LVL_W   = 3;
  localparam int LVL_MAX = 7;
  localparam int PCT_W   = 7;

  // Map a core's share of the queue onto eight levels, 0 = most urgent.
  function automatic logic [LVL_W-1:0] share_to_level(input int unsigned cnt,
                                                      input int unsigned total);
    int unsigned steps;
    steps = 0;
    if (total == 0) return LVL_W'(LVL_MAX);
    for (int k = 1; k <= LVL_MAX; k++) begin
      if (cnt * 8 >= k * total) steps = k;
    end
    return LVL_W'(LVL_MAX - steps);
  endfunction
endpackage

// File: rtl/gcs_entry_table.sv
module gcs_entry_table #(
  parameter int DEPTH  = 8,
  parameter int NCORE  = 4,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             enq_valid,
  input  logic [IDX_W-1:0]                 enq_idx,
  input  logic [CORE_W-1:0]                enq_core,
  input  logic                             deq_valid,
  input  logic [IDX_W-1:0]                 deq_idx,
  output logic [DEPTH-1:0]                 ent_valid,
  output logic [DEPTH-1:0][CORE_W-1:0]     ent_core,
  output logic [DEPTH-1:0][DEPTH-1:0]      older,
  output logic [NCORE-1:0][CNT_W-1:0]      core_cnt,
  output logic [CNT_W-1:0]                 total
);
  logic [DEPTH-1:0] deq_hit;
  logic [DEPTH-1:0] enq_hit;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign deq_hit[i] = deq_valid && (deq_idx == IDX_W'(i)) && ent_valid[i];
      assign enq_hit[i] = enq_valid && (enq_idx == IDX_W'(i)) &&
                          (!ent_valid[i] || deq_hit[i]);

      always_ff @(posedge clk) begin
        if (rst) begin
          ent_valid[i] <= 1'b0;
          ent_core[i]  <= '0;
        end else begin
          if (enq_hit[i]) begin
            ent_valid[i] <= 1'b1;
            ent_core[i]  <= enq_core;
          end else if (deq_hit[i]) begin
            ent_valid[i] <= 1'b0;
          end
        end
      end

      // older[i][j]: slot i arrived before slot j
      for (genvar j = 0; j < DEPTH; j++) begin : g_age
        always_ff @(posedge clk) begin
          if (rst) begin
            older[i][j] <= 1'b0;
          end else if (enq_hit[i]) begin
            older[i][j] <= 1'b0;
          end else if (enq_hit[j]) begin
            older[i][j] <= 1'b1;
          end
        end
      end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_cnt
      always_comb begin
        core_cnt[c] = '0;
        for (int i = 0; i < DEPTH; i++) begin
          if (ent_valid[i] && ent_core[i] == CORE_W'(c))
            core_cnt[c] = core_cnt[c] + CNT_W'(1);
        end
      end
    end
  endgenerate

  always_comb begin
    total = '0;
    for (int c = 0; c < NCORE; c++) total = total + core_cnt[c];
  end
endmodule

// File: rtl/gcs_level_tracker.sv
module gcs_level_tracker
  import gcs_pkg::*;
#(
  parameter int NCORE   = 4,
  parameter int CNT_W   = 4,
  parameter int EPOCH_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NCORE-1:0][CNT_W-1:0]      core_cnt,
  input  logic [CNT_W-1:0]                 total,
  input  logic [EPOCH_W-1:0]               epoch_len,
  output logic [NCORE-1:0][LVL_W-1:0]      lvl,
  output logic                             fire
);
  logic [EPOCH_W-1:0] ep_cnt;

  assign fire = (ep_cnt >= epoch_len);

  always_ff @(posedge clk) begin
    if (rst)       ep_cnt <= '0;
    else if (fire) ep_cnt <= '0;
    else           ep_cnt <= ep_cnt + EPOCH_W'(1);
  end

  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_lvl
      logic [LVL_W-1:0] lvl_next;
      assign lvl_next = share_to_level(int'(core_cnt[c]), int'(total));
      always_ff @(posedge clk) begin
        if (rst)       lvl[c] <= LVL_W'(LVL_MAX);
        else if (fire) lvl[c] <= lvl_next;
      end
    end
  endgenerate
endmodule

// File: rtl/gcs_picker.sv
module gcs_picker
  import gcs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NCORE = 4,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PRD_W  = CNT_W + PCT_W + 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [DEPTH-1:0]                 ent_valid,
  input  logic [DEPTH-1:0][CORE_W-1:0]     ent_core,
  input  logic [DEPTH-1:0][DEPTH-1:0]      older,
  input  logic [DEPTH-1:0]                 row_hit,
  input  logic [NCORE-1:0][LVL_W-1:0]      lvl,
  input  logic [CNT_W-1:0]                 total,
  input  logic [LVL_W-1:0]                 t_cr,
  input  logic [PCT_W-1:0]                 t_ms,
  output logic [DEPTH-1:0]                 ent_crit,
  output logic                             sel_valid_o,
  output logic [IDX_W-1:0]                 sel_idx_o,
  output logic                             crit_mode_o
);
  logic [NCORE-1:0]       core_crit;
  logic [CNT_W-1:0]       n_crit;
  logic [PRD_W-1:0]       crit_pct;
  logic [PRD_W-1:0]       lim_pct;
  logic                   mode_c;
  logic [DEPTH-1:0][1:0]  key;
  logic [DEPTH-1:0]       win;
  logic [IDX_W-1:0]       win_idx;

  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_core
      assign core_crit[c] = (lvl[c] <= t_cr);
    end
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign ent_crit[i] = ent_valid[i] && core_crit[ent_core[i]];
      assign key[i] = {mode_c && ent_crit[i], row_hit[i]};
    end
  endgenerate

  always_comb begin
    n_crit = '0;
    for (int i = 0; i < DEPTH; i++) n_crit = n_crit + CNT_W'(ent_crit[i]);
  end

  assign crit_pct = PRD_W'(n_crit) * PRD_W'(100);
  assign lim_pct  = PRD_W'(t_ms) * PRD_W'(total);
  assign mode_c   = (crit_pct <= lim_pct);

  // Slot i wins when it beats or ties-and-predates every other occupied slot.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_win
      always_comb begin
        win[i] = ent_valid[i];
        for (int j = 0; j < DEPTH; j++) begin
          if (j != i && ent_valid[j]) begin
            if (key[i] < key[j]) win[i] = 1'b0;
            else if (key[i] == key[j] && !older[i][j]) win[i] = 1'b0;
          end
        end
      end
    end
  endgenerate

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (win[i]) win_idx = win_idx | IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid_o <= 1'b0;
      sel_idx_o   <= '0;
      crit_mode_o <= 1'b0;
    end else begin
      sel_valid_o <= |ent_valid;
      sel_idx_o   <= win_idx;
      crit_mode_o <= mode_c;
    end
  end
endmodule

// File: rtl/gpu_crit_sched.sv
module gpu_crit_sched
  import gcs_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NCORE   = 4,
  parameter int EPOCH_W = 8,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enq_valid,
  input  logic [IDX_W-1:0]         enq_idx,
  input  logic [CORE_W-1:0]        enq_core,
  input  logic                     deq_valid,
  input  logic [IDX_W-1:0]         deq_idx,
  input  logic [DEPTH-1:0]         row_hit,
  input  logic [LVL_W-1:0]         t_cr,
  input  logic [PCT_W-1:0]         t_ms,
  input  logic [EPOCH_W-1:0]       epoch_len,
  output logic                     sel_valid_o,
  output logic [IDX_W-1:0]         sel_idx_o,
  output logic                     crit_mode_o,
  output logic [NCORE*LVL_W-1:0]   lvl_o
);
  logic [DEPTH-1:0]                ent_valid;
  logic [DEPTH-1:0][CORE_W-1:0]    ent_core;
  logic [DEPTH-1:0][DEPTH-1:0]     older;
  logic [NCORE-1:0][CNT_W-1:0]     core_cnt;
  logic [CNT_W-1:0]                total;
  logic [NCORE-1:0][LVL_W-1:0]     lvl;
  logic                            lvl_fire;
  logic [DEPTH-1:0]                ent_crit;

  gcs_entry_table #(.DEPTH(DEPTH), .NCORE(NCORE)) u_table (
    .clk(clk), .rst(rst),
    .enq_valid(enq_valid), .enq_idx(enq_idx), .enq_core(enq_core),
    .deq_valid(deq_valid), .deq_idx(deq_idx),
    .ent_valid(ent_valid), .ent_core(ent_core), .older(older),
    .core_cnt(core_cnt), .total(total)
  );

  gcs_level_tracker #(.NCORE(NCORE), .CNT_W(CNT_W), .EPOCH_W(EPOCH_W)) u_level (
    .clk(clk), .rst(rst),
    .core_cnt(core_cnt), .total(total), .epoch_len(epoch_len),
    .lvl(lvl), .fire(lvl_fire)
  );

  gcs_picker #(.DEPTH(DEPTH), .NCORE(NCORE)) u_pick (
    .clk(clk), .rst(rst),
    .ent_valid(ent_valid), .ent_core(ent_core), .older(older),
    .row_hit(row_hit), .lvl(lvl), .total(total),
    .t_cr(t_cr), .t_ms(t_ms),
    .ent_crit(ent_crit),
    .sel_valid_o(sel_valid_o), .sel_idx_o(sel_idx_o), .crit_mode_o(crit_mode_o)
  );

  assign lvl_o = lvl;
endmodule

// File: rtl/gcs_checker.sv
module gcs_checker #(
  parameter int DEPTH = 8,
  parameter int NCORE = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [DEPTH-1:0]       ent_valid,
  input logic [DEPTH-1:0]       ent_crit,
  input logic [CNT_W-1:0]       total,
  input logic                   lvl_fire,
  input logic [NCORE*3-1:0]     lvl_o,
  input logic                   sel_valid_o,
  input logic [IDX_W-1:0]       sel_idx_o,
  input logic                   crit_mode_o
);
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] crit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      crit_q  <= '0;
    end else begin
      valid_q <= ent_valid;
      crit_q  <= ent_crit;
    end
  end

  // R1: sum of per-core counts equals the number of occupied slots
  a_r1_count_sum: assert property (@(posedge clk) disable iff (rst)
    int'(total) == $countones(ent_valid));

  // R3: levels hold when no refresh is due
  a_r3_level_hold: assert property (@(posedge clk) disable iff (rst)
    !lvl_fire |=> $stable(lvl_o));

  // R8: empty table gives no selection on the next cycle
  a_r8_empty_idle: assert property (@(posedge clk) disable iff (rst)
    (ent_valid == '0) |=> !sel_valid_o);

  // R9: a valid selection points at a slot that was occupied
  a_r9_sel_occupied: assert property (@(posedge clk) disable iff (rst)
    sel_valid_o |-> valid_q[sel_idx_o]);

  // R6: in criticality mode a critical slot wins whenever one was waiting
  a_r6_crit_first: assert property (@(posedge clk) disable iff (rst)
    (sel_valid_o && crit_mode_o && crit_q != '0) |-> crit_q[sel_idx_o]);
endmodule

bind gpu_crit_sched gcs_checker #(.DEPTH(DEPTH), .NCORE(NCORE)) u_chk (
  .clk(clk), .rst(rst), .ent_valid(ent_valid), .ent_crit(ent_crit),
  .total(total), .lvl_fire(lvl_fire), .lvl_o(lvl_o),
  .sel_valid_o(sel_valid_o), .sel_idx_o(sel_idx_o), .crit_mode_o(crit_mode_o)
);

// File: tb/tb_gpu_crit_sched.sv
`timescale 1ns/1ps
module tb_gpu_crit_sched;
  localparam int DEPTH = 8;
  localparam int NCORE = 4;
  localparam int EW    = 8;

  logic clk = 1'b0;
  logic rst;
  logic enq_valid, deq_valid;
  logic [2:0] enq_idx, deq_idx;
  logic [1:0] enq_core;
  logic [DEPTH-1:0] row_hit;
  logic [2:0] t_cr;
  logic [6:0] t_ms;
  logic [EW-1:0] epoch_len;
  logic sel_valid_o, crit_mode_o;
  logic [2:0] sel_idx_o;
  logic [NCORE*3-1:0] lvl_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpu_crit_sched #(.DEPTH(DEPTH), .NCORE(NCORE), .EPOCH_W(EW)) dut (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_idx(enq_idx),
    .enq_core(enq_core), .deq_valid(deq_valid), .deq_idx(deq_idx),
    .row_hit(row_hit), .t_cr(t_cr), .t_ms(t_ms), .epoch_len(epoch_len),
    .sel_valid_o(sel_valid_o), .sel_idx_o(sel_idx_o),
    .crit_mode_o(crit_mode_o), .lvl_o(lvl_o)
  );

  // reference model state
  bit m_v[DEPTH];
  int m_core[DEPTH];
  int m_stamp[DEPTH];
  int m_lvl[NCORE];
  int m_ep, m_seq;
  bit e_valid, e_mode;
  int e_idx;

  function automatic int quant(int cnt, int total);
    int s;
    if (total == 0) return 7;
    s = (cnt * 8) / total;
    if (s > 7) s = 7;
    return 7 - s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
      for (int c = 0; c < NCORE; c++) m_lvl[c] = 7;
      m_ep = 0; m_seq = 0; e_valid = 0; e_idx = 0; e_mode = 0;
    end else begin
      int total, ncrit, best, kb, ki;
      int cnt[NCORE];
      bit crit[DEPTH];
      bit mode;
      total = 0; ncrit = 0;
      for (int c = 0; c < NCORE; c++) cnt[c] = 0;
      for (int i = 0; i < DEPTH; i++) if (m_v[i]) begin
        cnt[m_core[i]]++; total++;
      end
      for (int i = 0; i < DEPTH; i++) begin
        crit[i] = m_v[i] && (m_lvl[m_core[i]] <= int'(t_cr));
        if (crit[i]) ncrit++;
      end
      mode = (ncrit * 100 <= int'(t_ms) * total);
      best = -1; kb = 0;
      for (int i = 0; i < DEPTH; i++) if (m_v[i]) begin
        ki = ((mode && crit[i]) ? 2 : 0) + (row_hit[i] ? 1 : 0);
        if (best < 0 || ki > kb || (ki == kb && m_stamp[i] < m_stamp[best])) begin
          best = i; kb = ki;
        end
      end
      e_valid = (best >= 0);
      e_idx = (best >= 0) ? best : 0;
      e_mode = mode;
      if (m_ep >= int'(epoch_len)) begin
        for (int c = 0; c < NCORE; c++) m_lvl[c] = quant(cnt[c], total);
        m_ep = 0;
      end else m_ep++;
      if (deq_valid && m_v[deq_idx]) m_v[deq_idx] = 0;
      if (enq_valid && !m_v[enq_idx]) begin
        m_v[enq_idx] = 1; m_core[enq_idx] = int'(enq_core);
        m_stamp[enq_idx] = m_seq; m_seq++;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(sel_valid_o == e_valid, e_valid ? "R9" : "R8", int'(sel_valid_o), int'(e_valid));
    chk(int'(sel_idx_o) == e_idx, e_mode ? "R6" : "R7", int'(sel_idx_o), e_idx);
    chk(crit_mode_o == e_mode, "R5", int'(crit_mode_o), int'(e_mode));
    for (int c = 0; c < NCORE; c++)
      chk(int'(lvl_o[c*3 +: 3]) == m_lvl[c], (epoch_len != 0) ? "R3" : "R2",
          int'(lvl_o[c*3 +: 3]), m_lvl[c]);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    compare();
    enq_valid = 0; deq_valid = 0;
  endtask

  task automatic enq(int idx, int core);
    enq_valid = 1; enq_idx = 3'(idx); enq_core = 2'(core);
    step();
  endtask

  initial begin
    #(4.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; enq_valid = 0; deq_valid = 0; enq_idx = 0; deq_idx = 0;
    enq_core = 0; row_hit = 0; t_cr = 3'd1; t_ms = 7'd50; epoch_len = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(sel_valid_o == 0 && sel_idx_o == 0 && crit_mode_o == 0, "R10",
        int'({sel_valid_o, sel_idx_o, crit_mode_o}), 0);
    chk(lvl_o == '1, "R10", int'(lvl_o), 12'hfff);
    rst = 0;
    step(); step();
    chk(sel_valid_o == 0, "R8", int'(sel_valid_o), 0);

    // 6 slots core0, 2 slots core1 -> levels 1 and 5 (R2)
    for (int i = 0; i < 6; i++) enq(i, 0);
    enq(6, 1); enq(7, 1);
    row_hit = 8'b1000_0000;
    step(); step();
    chk(int'(lvl_o[2:0]) == 1, "R2", int'(lvl_o[2:0]), 1);
    chk(int'(lvl_o[5:3]) == 5, "R2", int'(lvl_o[5:3]), 5);
    // 6 critical of 8: 600 > 400 -> row-hit-first (R5, R7)
    chk(crit_mode_o == 0, "R5", int'(crit_mode_o), 0);
    chk(sel_idx_o == 3'd7, "R7", int'(sel_idx_o), 7);
    // t_ms=80: 600 <= 640 -> criticality first (R4, R6)
    t_ms = 7'd80; step();
    chk(crit_mode_o == 1, "R4", int'(crit_mode_o), 1);
    chk(sel_idx_o == 3'd0, "R6", int'(sel_idx_o), 0);
    row_hit = 8'b1000_1000; step();
    chk(sel_idx_o == 3'd3, "R6", int'(sel_idx_o), 3);
    // enqueue to occupied slot is ignored (R1)
    enq(0, 2); step(); step();
    chk(int'(lvl_o[2:0]) == 1, "R1", int'(lvl_o[2:0]), 1);
    chk(int'(lvl_o[8:6]) == 7, "R1", int'(lvl_o[8:6]), 7);
    // same-cycle dequeue and enqueue of slot 0: slot becomes youngest (R1)
    deq_valid = 1; deq_idx = 0; row_hit = 0; enq(0, 0); step();
    chk(sel_idx_o == 3'd1, "R1", int'(sel_idx_o), 1);

    // random phase with periodic parameter changes (R3, R5, R6, R7)
    for (int n = 0; n < 6000; n++) begin
      if (n % 400 == 0) begin
        epoch_len = EW'($urandom_range(0, 31));
        t_cr = 3'($urandom_range(0, 7));
        t_ms = 7'($urandom_range(0, 100));
      end
      enq_valid = ($urandom_range(0, 9) < 6);
      enq_idx = 3'($urandom); enq_core = 2'($urandom);
      deq_valid = ($urandom_range(0, 9) < 4);
      deq_idx = 3'($urandom);
      row_hit = 8'($urandom);
      step();
    end

    // drain and confirm the idle selection (R8)
    epoch_len = 0;
    for (int i = 0; i < DEPTH; i++) begin
      deq_valid = 1; deq_idx = 3'(i); step();
    end
    step(); step();
    chk(sel_valid_o == 0 && sel_idx_o == 0, "R8", int'(sel_valid_o), 0);
    chk(lvl_o == '1, "R2", int'(lvl_o), 12'hfff);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule